// File: doc/BRIEF.md
# Dual-Master Bus Arbiter with Periodic Refresh Stall

This block decides, cycle by cycle, which of two masters owns a shared system bus. The primary master is a 16-bit main CPU. The secondary master is an 8-bit sound CPU that reaches main-bus memory through a banked window. When the sound CPU raises its request, the arbiter waits for any main-CPU cycle already under way to finish. It then holds the main CPU paused, gives the sound CPU exactly one access, and hands the bus back to the main CPU if the main CPU is still asking for it. The arbiter holds off the sound CPU while a video DMA from main memory is running or while the main CPU is stuck on a video FIFO full or empty condition.

A free-running counter arms a refresh steal once per period. The next bus access to begin, from either master, takes the steal and is stretched by a fixed number of extra clocks. The one exception is a main-CPU write to a video port: that access uses up the steal but is not stretched. A master signals the end of its access with a one-clock done strobe. The arbiter ignores that strobe while the access is being stretched.

Top module: `dual_master_arbiter`

## Requirements
- R1: While reset is asserted and on the first clock after it, `main_gnt`, `snd_gnt`, `main_wait` and `snd_wait` are low when no request is raised.
- R2: From an idle bus, a main request or an unblocked sound request starts an access on the next rising edge. A main grant is visible after that edge.
- R3: While the main CPU holds the grant and has not yet completed with `main_done`, a sound request does not take the bus away. `main_gnt` stays high and `snd_gnt` stays low.
- R4: While the sound CPU owns the bus, a pending main request sees `main_wait` high and `main_gnt` low. After the sound access ends, a still-pending main request is served before any further sound access. The main access starts on the second rising edge after the sound done strobe.
- R5: A grant drops on the clock after the done strobe of its master is sampled. A done strobe is not honoured during a stretch.
- R6: While `dma_busy` or `fifo_stall` is high, no sound access begins and `snd_wait` stays high. The access starts on the first rising edge after both inputs are low.
- R7: The refresh counter starts at zero at reset and counts every clock. A steal is armed on each rising edge whose number since reset is a multiple of PERIOD. An armed steal stays pending until an access starts.
- R8: An access that starts with a steal pending is stretched by STEAL clocks. For the main CPU, `main_gnt` is high with `main_wait` high during those clocks. For the sound CPU, `snd_gnt` is held low for those clocks after the access starts.
- R9: A main access flagged by `main_vid_wr` as a write to a video port is never stretched, and it still uses up any pending steal.
- R10: `main_gnt` and `snd_gnt` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| main_req | input | 1 | Main CPU wants the bus (held until its done strobe) |
| main_vid_wr | input | 1 | Current main request is a write to a video port |
| main_done | input | 1 | One-clock strobe: main access finished |
| main_gnt | output | 1 | Main CPU owns the bus |
| main_wait | output | 1 | Main CPU must stall (paused or stretched) |
| snd_req | input | 1 | Sound CPU wants one access (held until its done strobe) |
| snd_done | input | 1 | One-clock strobe: sound access finished |
| snd_gnt | output | 1 | Sound CPU may drive its access |
| snd_wait | output | 1 | Sound CPU request pending without grant |
| dma_busy | input | 1 | Video DMA from main memory is active |
| fifo_stall | input | 1 | Main CPU held by a video FIFO full/empty stall |

## Verification
The bench builds the arbiter with PERIOD = 16 and STEAL = 2. A refresh period this short lets each sweep walk a main access and a sound access across every phase of the refresh counter, including a request placed on the arming edge itself. With those values, stretches that fall on a skipped video write, back-to-back accesses that find no steal left, and a sound access squeezed between two main accesses all occur within a few hundred clocks. The expected stretch for each access comes from edge arithmetic on the refresh phase and the edge on which the previous access began.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_MAIN = 2'd1,
    OWN_SND  = 2'd2
  } owner_e;

endpackage

// File: rtl/busarb_refresh.sv
module busarb_refresh #(
  parameter int PERIOD = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;

  function automatic logic at_wrap(input logic [CW-1:0] c);
    return c == CW'(PERIOD - 1);
  endfunction

  assign tick = at_wrap(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (PERIOD > 1) begin : g_tick_chk
      assert_tick_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/busarb_steal.sv
module busarb_steal #(
  parameter int STEAL = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic skip,
  output logic armed,
  output logic stalling
);

  localparam int SW = $clog2(STEAL + 1);

  logic [SW-1:0] stall_q;
  logic          armed_q;

  function automatic logic [SW-1:0] stretch_len(input logic arm, input logic skp);
    return (arm && !skp) ? SW'(STEAL) : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      stall_q <= '0;
    end else begin
      armed_q <= (armed_q & ~start) | tick;
      if (start) stall_q <= stretch_len(armed_q, skip);
      else if (stall_q != '0) stall_q <= stall_q - 1'b1;
    end
  end

  assign armed    = armed_q;
  assign stalling = (stall_q != '0);

  assert_tick_arms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> armed);
  assert_stall_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q <= SW'(STEAL));
  assert_armed_start_stretches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && armed && !skip) |=> stalling);
  assert_skip_no_stretch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && skip) |=> !stalling);
  assert_steal_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !start) |=> armed);

endmodule

// File: rtl/busarb_owner.sv
module busarb_owner
  import busarb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   m_req,
  input  logic   m_done,
  input  logic   s_req,
  input  logic   s_done,
  input  logic   blocked,
  input  logic   stalling,
  output owner_e owner,
  output logic   start,
  output logic   start_main
);

  owner_e state_q, state_n;
  logic   last_snd_q, last_snd_n;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      OWN_IDLE: begin
        if (last_snd_q && m_req)  state_n = OWN_MAIN;
        else if (s_req && !blocked) state_n = OWN_SND;
        else if (m_req)           state_n = OWN_MAIN;
      end
      OWN_MAIN: if (!stalling && m_done) state_n = OWN_IDLE;
      OWN_SND:  if (!stalling && s_done) state_n = OWN_IDLE;
      default:  state_n = OWN_IDLE;
    endcase
  end

  assign start      = (state_q == OWN_IDLE) && (state_n != OWN_IDLE);
  assign start_main = start && (state_n == OWN_MAIN);

  always_comb begin
    last_snd_n = last_snd_q;
    if (state_q == OWN_SND && state_n == OWN_IDLE) last_snd_n = 1'b1;
    else if (start) last_snd_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= OWN_IDLE;
      last_snd_q <= 1'b0;
    end else begin
      state_q    <= state_n;
      last_snd_q <= last_snd_n;
    end
  end

  assign owner = state_q;

  assert_main_finishes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OWN_MAIN && !m_done) |=> state_q == OWN_MAIN);
  assert_stretch_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != OWN_IDLE && stalling) |=> state_q == $past(state_q));
  assert_snd_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OWN_SND && !stalling && s_done) |=> state_q == OWN_IDLE);
  assert_blocked_no_snd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OWN_IDLE && blocked) |=> state_q != OWN_SND);
  assert_main_resumes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OWN_IDLE && last_snd_q && m_req) |=> state_q == OWN_MAIN);

endmodule

// File: rtl/dual_master_arbiter.sv
module dual_master_arbiter
  import busarb_pkg::*;
#(
  parameter int PERIOD = 128,
  parameter int STEAL  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic main_req,
  input  logic main_vid_wr,
  input  logic main_done,
  output logic main_gnt,
  output logic main_wait,
  input  logic snd_req,
  input  logic snd_done,
  output logic snd_gnt,
  output logic snd_wait,
  input  logic dma_busy,
  input  logic fifo_stall
);

  logic   refresh_tick;
  logic   steal_armed;
  logic   stretch_active;
  logic   access_start;
  logic   access_start_main;
  logic   snd_blocked;
  logic   skip_steal;
  owner_e owner;

  assign snd_blocked = dma_busy | fifo_stall;
  assign skip_steal  = access_start_main & main_vid_wr;

  busarb_refresh #(.PERIOD(PERIOD)) u_refresh (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (refresh_tick)
  );

  busarb_steal #(.STEAL(STEAL)) u_steal (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (refresh_tick),
    .start    (access_start),
    .skip     (skip_steal),
    .armed    (steal_armed),
    .stalling (stretch_active)
  );

  busarb_owner u_owner (
    .clk        (clk),
    .rst_n      (rst_n),
    .m_req      (main_req),
    .m_done     (main_done),
    .s_req      (snd_req),
    .s_done     (snd_done),
    .blocked    (snd_blocked),
    .stalling   (stretch_active),
    .owner      (owner),
    .start      (access_start),
    .start_main (access_start_main)
  );

  assign main_gnt  = (owner == OWN_MAIN);
  assign snd_gnt   = (owner == OWN_SND) && !stretch_active;
  assign main_wait = main_req && (!main_gnt || stretch_active);
  assign snd_wait  = snd_req && !snd_gnt;

  assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_gnt && snd_gnt));
  assert_snd_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_gnt && snd_done) |=> !snd_gnt);
  assert_main_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (main_gnt && !main_wait && main_done) |=> !main_gnt);
  assert_paused_main_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_gnt && main_req) |-> main_wait);
  assert_steal_unused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (steal_armed && owner == OWN_IDLE && !main_req && !snd_req) |=> steal_armed);

endmodule

// File: tb/tb_dual_master_arbiter.sv
module tb_dual_master_arbiter;

  localparam int P  = 16;
  localparam int ST = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic main_req = 0, main_vid_wr = 0, main_done = 0;
  logic snd_req = 0, snd_done = 0, dma_busy = 0, fifo_stall = 0;
  logic main_gnt, main_wait, snd_gnt, snd_wait;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_start = 0;
  int overlaps = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dual_master_arbiter #(.PERIOD(P), .STEAL(ST)) dut (
    .clk(clk), .rst_n(rst_n),
    .main_req(main_req), .main_vid_wr(main_vid_wr), .main_done(main_done),
    .main_gnt(main_gnt), .main_wait(main_wait),
    .snd_req(snd_req), .snd_done(snd_done),
    .snd_gnt(snd_gnt), .snd_wait(snd_wait),
    .dma_busy(dma_busy), .fifo_stall(fifo_stall)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  always @(negedge clk) if (rst_n && main_gnt && snd_gnt) overlaps++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // steal pending for an access starting on edge e: the latest arming edge
  // before e (a multiple of P) is not older than the previous start edge
  function automatic int stretch_at(input int e, input bit vid);
    int t;
    t = ((e - 1) / P) * P;
    return (t >= P && t >= last_start && !vid) ? ST : 0;
  endfunction

  task automatic main_access(input bit vid, input string tag);
    int e, exp, n;
    e = cyc + 1;
    exp = stretch_at(e, vid);
    main_req = 1; main_vid_wr = vid;
    step();
    chk(main_gnt == 1'b1, "R2 main grant", int'(main_gnt), 1);
    n = 0;
    while (main_wait && n < 10) begin n++; step(); end
    chk(n == exp, tag, n, exp);
    last_start = e;
    main_done = 1; main_req = 0; main_vid_wr = 0;
    step();
    main_done = 0;
    chk(main_gnt == 1'b0, "R5 main grant drop", int'(main_gnt), 0);
  endtask

  task automatic snd_access(input string tag);
    int e, exp, n;
    e = cyc + 1;
    exp = stretch_at(e, 1'b0);
    snd_req = 1;
    step();
    n = 0;
    while (!snd_gnt && n < 40) begin n++; step(); end
    chk(n == exp, tag, n, exp);
    last_start = e;
    snd_done = 1; snd_req = 0;
    step();
    snd_done = 0;
    chk(snd_gnt == 1'b0, "R5 snd grant drop", int'(snd_gnt), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int bad, e, k, es, em, n, exp;
    step();
    chk(!main_gnt && !snd_gnt && !main_wait && !snd_wait, "R1 in reset",
        int'({main_gnt, snd_gnt, main_wait, snd_wait}), 0);
    step();
    rst_n = 1;
    step();
    chk(!main_gnt && !snd_gnt && !main_wait && !snd_wait, "R1 after reset",
        int'({main_gnt, snd_gnt, main_wait, snd_wait}), 0);

    // first accesses before any arming edge: no stretch (R7)
    main_access(1'b0, "R7 no steal before first period");
    snd_access("R7 snd no steal before first period");

    // sweep main accesses across every refresh phase (R8, R9)
    for (int off = 0; off < P + 3; off++) begin
      repeat (off) step();
      main_access(off % 3 == 1, (off % 3 == 1) ? "R9 video write skip" : "R8 main stretch");
    end

    // sweep sound accesses across every refresh phase (R8)
    for (int off = 0; off < P + 3; off++) begin
      repeat (off) step();
      snd_access("R8 snd stretch");
    end

    // skipped steal is consumed: arm, video write, then plain access (R9)
    repeat (P + 1) step();
    main_access(1'b1, "R9 skip on armed");
    main_access(1'b0, "R9 steal consumed by skip");

    // contention: main in progress, sound waits, then one sound access (R3, R4)
    repeat (5) step();
    e = cyc + 1;
    exp = stretch_at(e, 1'b0);
    main_req = 1;
    step();
    last_start = e;
    snd_req = 1;
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      if (!main_gnt || snd_gnt) bad++;
      step();
    end
    chk(bad == 0, "R3 main cycle completes first", bad, 0);
    main_done = 1;
    es = cyc + 2;
    step();
    main_done = 0;
    chk(main_wait && !main_gnt, "R4 main paused", int'({main_wait, main_gnt}), 2);
    exp = stretch_at(es, 1'b0);
    k = 0;
    while (!snd_gnt && k < 40) begin k++; step(); end
    chk(k == 1 + exp, "R4 snd delay window", k, 1 + exp);
    chk(main_wait && !main_gnt, "R4 main held during snd", int'({main_wait, main_gnt}), 2);
    last_start = es;
    snd_done = 1;
    em = cyc + 2;
    step();
    snd_done = 0;
    chk(!snd_gnt && !main_gnt, "R5 snd drop before resume", int'({snd_gnt, main_gnt}), 0);
    snd_req = 1;  // sound asks again at once: main must go first
    step();
    chk(main_gnt && !snd_gnt, "R4 main resumes first", int'({main_gnt, snd_gnt}), 2);
    exp = stretch_at(em, 1'b0);
    last_start = em;
    n = 0;
    while (main_wait && n < 10) begin n++; step(); end
    chk(n == exp, "R8 resumed main stretch", n, exp);
    main_done = 1; main_req = 0;
    step();
    main_done = 0;
    last_start = cyc + 1;
    step();
    chk(snd_gnt || snd_wait, "R4 snd served after main", int'(snd_gnt), 1);
    while (!snd_gnt) step();
    snd_done = 1; snd_req = 0;
    step();
    snd_done = 0;

    // blocking by DMA, then by FIFO stall (R6)
    for (int src = 0; src < 2; src++) begin
      repeat (3) step();
      if (src == 0) dma_busy = 1; else fifo_stall = 1;
      snd_req = 1;
      bad = 0;
      for (int i = 0; i < 2 * P; i++) begin
        step();
        if (snd_gnt || !snd_wait) bad++;
      end
      chk(bad == 0, src == 0 ? "R6 dma blocks snd" : "R6 fifo stall blocks snd", bad, 0);
      e = cyc + 1;
      exp = stretch_at(e, 1'b0);
      dma_busy = 0; fifo_stall = 0;
      step();
      k = 0;
      while (!snd_gnt && k < 40) begin k++; step(); end
      chk(k == exp, "R6 snd starts when unblocked", k, exp);
      last_start = e;
      snd_done = 1; snd_req = 0;
      step();
      snd_done = 0;
    end

    chk(overlaps == 0, "R10 grants never overlap", overlaps, 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule